// File: doc/BRIEF.md
# VLAN Table Command Engine

This block holds a small table of VLAN entries and lets a host manage it through a handful of registers. Each entry holds a 12-bit VLAN ID, a valid flag, a filtering database number and a packed data field carrying a 2-bit membership code and a 2-bit port state per port. The host fills staging registers (the VID register and the data registers), then writes the operation register with its busy bit set to start a command. It polls that bit until it clears before it issues the next command.

Three commands exist. Load/purge installs or removes the entry named by the VID register. Flush-all empties the table. Get-next looks for the valid entry with the lowest VID strictly above the VID register. It visits one table slot per clock and writes the entry it finds back into the staging registers. Issuing get-next again therefore walks the table in ascending VID order. A result of VID 0xFFF with valid clear marks the end of the walk.

The host side is a plain register port: one write strobe, one address used for both writes and reads, and combinational read data. It has no back-pressure. Instead, the busy bit tells the host when it may write again.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset the operation, VID and data registers read 0x0000 and the table holds no valid entry.
- R2: A write to the operation register (address 0) with bit 15 set, while not busy, starts the command coded in bits 14:12: 001 flush-all, 011 load/purge, 100 get-next. Bit 15 reads 1 while the command runs. Load/purge and flush-all clear it after 1 cycle. Get-next clears it after ENTRIES cycles.
- R3: The VID register (address 1) holds the VLAN ID in bits 11:0 and the valid flag in bit 12. Bits 15:13 read 0. Data registers sit at addresses 2, 3 and 4. Port i uses data register i/4, with its membership code at bit (i%4)*4 and its state two bits higher.
- R4: Load/purge with the valid flag set writes the VID, the data registers and the database number into the entry with the same VID if one exists, otherwise into the lowest free slot.
- R5: Load/purge with the valid flag clear invalidates the entry whose VID matches. If no entry matches, the table is unchanged.
- R6: Get-next writes the lowest valid VID strictly above the VID register into the VID register with valid set, and copies that entry's data into the data registers. Repeating get-next without rewriting the VID register visits the entries in ascending order.
- R7: When no valid VID lies above the VID register, get-next leaves VID 0xFFF with valid clear.
- R8: The database number travels in operation bits 3:0 (low nibble) and 11:8 (high nibble). It is stored masked to DB_COUNT-1, and get-next returns it in the same fields with bits 7:4 reading 0.
- R9: Flush-all invalidates every entry.
- R10: While busy, writes to any register are ignored.
- R11: Load/purge of a new valid VID into a full table leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register, combinational |

## Verification
Register writes take effect at the clock edge that samples the strobe, and reads are combinational. The bench therefore drives and samples on the falling edge and reads a result one half-cycle after the write that set it. Busy is counted in falling edges after the operation write. It must read 1 for exactly one edge for load/purge and flush-all, and for ENTRIES edges for get-next. Get-next results are checked only once busy has fallen, because the VID, data and database fields are all updated at the edge where busy clears.

// File: rtl/vtab_pkg.sv
package vtab_pkg;
  localparam int VID_W = 12;
  localparam int REG_W = 16;
  localparam logic [VID_W-1:0] VID_END = '1;
  localparam logic [2:0] ADDR_OP    = 3'd0;
  localparam logic [2:0] ADDR_VID   = 3'd1;
  localparam logic [2:0] ADDR_DATA0 = 3'd2;
  localparam int OP_BUSY   = 15;
  localparam int VID_VALID = 12;
  typedef enum logic [2:0] {
    CMD_NONE  = 3'b000,
    CMD_FLUSH = 3'b001,
    CMD_LOAD  = 3'b011,
    CMD_NEXT  = 3'b100
  } vtab_cmd_e;
endpackage

// File: rtl/vtab_store.sv
module vtab_store
  import vtab_pkg::*;
#(
  parameter int E     = 16,
  parameter int DB_W  = 6,
  parameter int DW    = 48,
  parameter int IDX_W = $clog2(E)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush_i,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic                       wr_valid_i,
  input  logic [VID_W-1:0]           wr_vid_i,
  input  logic [DB_W-1:0]            wr_db_i,
  input  logic [DW-1:0]              wr_data_i,
  output logic [E-1:0]               valid_o,
  output logic [E-1:0][VID_W-1:0]    vid_o,
  output logic [E-1:0][DB_W-1:0]     db_o,
  output logic [E-1:0][DW-1:0]       data_o
);
  for (genvar g = 0; g < E; g++) begin : g_slot
    logic             v_q;
    logic [VID_W-1:0] vid_q;
    logic [DB_W-1:0]  db_q;
    logic [DW-1:0]    dat_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q   <= 1'b0;
        vid_q <= '0;
        db_q  <= '0;
        dat_q <= '0;
      end else if (flush_i) begin
        v_q <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        v_q   <= wr_valid_i;
        vid_q <= wr_vid_i;
        db_q  <= wr_db_i;
        dat_q <= wr_data_i;
      end
    end
    assign valid_o[g] = v_q;
    assign vid_o[g]   = vid_q;
    assign db_o[g]    = db_q;
    assign data_o[g]  = dat_q;
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_o == '0)); // R9
endmodule

// File: rtl/vtab_match.sv
module vtab_match
  import vtab_pkg::*;
#(
  parameter int E     = 16,
  parameter int IDX_W = $clog2(E)
) (
  input  logic [E-1:0]            valid_i,
  input  logic [E-1:0][VID_W-1:0] vid_i,
  input  logic [VID_W-1:0]        key_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        hit_idx_o,
  output logic                    free_o,
  output logic [IDX_W-1:0]        free_idx_o
);
  always_comb begin
    hit_o      = 1'b0;
    hit_idx_o  = '0;
    free_o     = 1'b0;
    free_idx_o = '0;
    for (int i = E - 1; i >= 0; i--) begin
      if (valid_i[i] && vid_i[i] == key_i) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(i);
      end
      if (!valid_i[i]) begin
        free_o     = 1'b1;
        free_idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vtab_scan.sv
module vtab_scan
  import vtab_pkg::*;
#(
  parameter int E     = 16,
  parameter int IDX_W = $clog2(E)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [VID_W-1:0]        key_i,
  input  logic [E-1:0]            valid_i,
  input  logic [E-1:0][VID_W-1:0] vid_i,
  output logic                    done_o,
  output logic                    found_o,
  output logic [IDX_W-1:0]        idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(E - 1);

  logic             run_q, found_q, hit;
  logic [IDX_W-1:0] cur_q, best_q;
  logic [VID_W-1:0] best_vid_q;

  assign hit = run_q && valid_i[cur_q] && (vid_i[cur_q] > key_i) &&
               (!found_q || vid_i[cur_q] < best_vid_q);
  assign done_o  = run_q && (cur_q == LAST);
  assign found_o = found_q || hit;
  assign idx_o   = hit ? cur_q : best_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      found_q    <= 1'b0;
      cur_q      <= '0;
      best_q     <= '0;
      best_vid_q <= '0;
    end else if (start_i) begin
      run_q   <= 1'b1;
      found_q <= 1'b0;
      cur_q   <= '0;
    end else if (run_q) begin
      if (hit) begin
        found_q    <= 1'b1;
        best_q     <= cur_q;
        best_vid_q <= vid_i[cur_q];
      end
      if (cur_q == LAST) run_q <= 1'b0;
      else               cur_q <= cur_q + 1'b1;
    end
  end

  AST_RESULT_ABOVE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && found_o) |-> (valid_i[idx_o] && vid_i[idx_o] > key_i)); // R6
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !run_q); // R10
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
  import vtab_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int PORTS    = 12,
  parameter int DB_COUNT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int DB_W  = $clog2(DB_COUNT);
  localparam int DREGS = (PORTS + 3) / 4;
  localparam int DW    = DREGS * REG_W;

  logic             busy_q;
  logic [2:0]       cmd_q;
  logic [7:0]       dbf_q;
  logic [VID_W-1:0] vid_q;
  logic             vld_q;
  logic [DW-1:0]    data_q;

  logic [ENTRIES-1:0]            t_valid;
  logic [ENTRIES-1:0][VID_W-1:0] t_vid;
  logic [ENTRIES-1:0][DB_W-1:0]  t_db;
  logic [ENTRIES-1:0][DW-1:0]    t_data;

  logic hit, free, scan_done, scan_found;
  logic [IDX_W-1:0] hit_idx, free_idx, scan_idx;

  logic accept, stage_we, exec_now, load_go, flush_go, wr_en;
  assign stage_we = bus_we && !busy_q;
  assign accept   = stage_we && bus_addr == ADDR_OP && bus_wdata[OP_BUSY];
  assign exec_now = busy_q && cmd_q != CMD_NEXT;
  assign load_go  = exec_now && cmd_q == CMD_LOAD;
  assign flush_go = exec_now && cmd_q == CMD_FLUSH;
  assign wr_en    = load_go && (hit || (vld_q && free));

  vtab_match #(.E(ENTRIES), .IDX_W(IDX_W)) u_match (
    .valid_i(t_valid), .vid_i(t_vid), .key_i(vid_q),
    .hit_o(hit), .hit_idx_o(hit_idx), .free_o(free), .free_idx_o(free_idx)
  );

  vtab_store #(.E(ENTRIES), .DB_W(DB_W), .DW(DW), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_go), .wr_en_i(wr_en),
    .wr_idx_i(hit ? hit_idx : free_idx), .wr_valid_i(vld_q),
    .wr_vid_i(vid_q), .wr_db_i(dbf_q[DB_W-1:0]), .wr_data_i(data_q),
    .valid_o(t_valid), .vid_o(t_vid), .db_o(t_db), .data_o(t_data)
  );

  vtab_scan #(.E(ENTRIES), .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .start_i(accept && bus_wdata[14:12] == CMD_NEXT),
    .key_i(vid_q), .valid_i(t_valid), .vid_i(t_vid),
    .done_o(scan_done), .found_o(scan_found), .idx_o(scan_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cmd_q  <= '0;
      dbf_q  <= '0;
      vid_q  <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (stage_we) begin
        if (bus_addr == ADDR_OP) begin
          busy_q <= bus_wdata[OP_BUSY];
          cmd_q  <= bus_wdata[14:12];
          dbf_q  <= {bus_wdata[11:8], bus_wdata[3:0]};
        end
        if (bus_addr == ADDR_VID) begin
          vid_q <= bus_wdata[VID_W-1:0];
          vld_q <= bus_wdata[VID_VALID];
        end
        for (int r = 0; r < DREGS; r++)
          if (bus_addr == 3'(ADDR_DATA0 + r)) data_q[r*REG_W +: REG_W] <= bus_wdata;
      end
      if (exec_now) busy_q <= 1'b0;
      if (scan_done) begin
        busy_q <= 1'b0;
        vld_q  <= scan_found;
        vid_q  <= scan_found ? t_vid[scan_idx] : VID_END;
        if (scan_found) begin
          data_q <= t_data[scan_idx];
          dbf_q  <= 8'(t_db[scan_idx]);
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_OP)
      bus_rdata = {busy_q, cmd_q, dbf_q[7:4], 4'b0000, dbf_q[3:0]};
    else if (bus_addr == ADDR_VID)
      bus_rdata = {3'b000, vld_q, vid_q};
    for (int r = 0; r < DREGS; r++)
      if (bus_addr == 3'(ADDR_DATA0 + r)) bus_rdata = data_q[r*REG_W +: REG_W];
  end

  AST_SHORT_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_q != CMD_NEXT) |=> !busy_q); // R2
  AST_NEXT_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_q == CMD_NEXT && !scan_done) |=> busy_q); // R2
  AST_BUSY_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bus_we && bus_addr == ADDR_OP) |=> $stable(cmd_q)); // R10
  AST_BUSY_VID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !scan_done && bus_we && bus_addr == ADDR_VID) |=> $stable(vid_q)); // R10
  AST_WALK_END: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && !scan_found) |=> (vid_q == VID_END && !vld_q)); // R7
  AST_PURGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_go && !vld_q && hit) |=> !t_valid[$past(hit_idx)]); // R5
endmodule

// File: tb/sim_vlan_cmd_engine.sv
module sim_vlan_cmd_engine;
  localparam int PERIOD = 10;
  localparam int ENTRIES = 16;
  localparam logic [7:0] DBMASK = 8'h3F;
  localparam int NV = 5;
  // {vid[12], db[8], d0, d1, d2}
  localparam logic [67:0] VEC [NV] = '{
    {12'h064, 8'hA7, 16'h1234, 16'h5678, 16'h9ABC},
    {12'h005, 8'h03, 16'hFFFF, 16'h0000, 16'h8421},
    {12'hFFE, 8'h3F, 16'hC3C3, 16'h0F0F, 16'h7E7E},
    {12'h3E8, 8'hFF, 16'h0001, 16'h8000, 16'hAAAA},
    {12'h001, 8'h40, 16'h5555, 16'h3333, 16'h0EE0}
  };

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  int checks = 0, errors = 0;

  vlan_cmd_engine u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
                      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic run_cmd(input logic [15:0] op, output int cyc);
    logic [15:0] v;
    wr(3'd0, op);
    cyc = 0; rd(3'd0, v);
    while (v[15] && cyc < 1000) begin
      cyc++; @(negedge clk); rd(3'd0, v);
    end
  endtask

  task automatic load(input logic [11:0] vid, input logic vl, input logic [7:0] db,
                      input logic [15:0] d0, d1, d2);
    int c;
    wr(3'd2, d0); wr(3'd3, d1); wr(3'd4, d2);
    wr(3'd1, {3'b000, vl, vid});
    run_cmd({4'b1011, db[7:4], 4'b0000, db[3:0]}, c);
    check("R2 load busy cycles", c, 1);
  endtask

  task automatic next_from(input logic [11:0] key, output logic [15:0] vr);
    int c;
    wr(3'd1, {4'b0000, key});
    run_cmd(16'hC000, c);
    check("R2 get-next busy cycles", c, ENTRIES);
    rd(3'd1, vr);
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, key;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, v); check("R1 op after reset", v, 16'h0000);
    rd(3'd1, v); check("R1 vid after reset", v, 16'h0000);
    for (int r = 2; r < 5; r++) begin rd(3'(r), v); check("R1 data after reset", v, 16'h0000); end
    next_from(12'h000, v); check("R1 empty table walk", v, 16'h0FFF);

    // Vector table: load all entries
    for (int i = 0; i < NV; i++)
      load(VEC[i][67:56], 1'b1, VEC[i][55:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);

    // R6 walk without rewriting VID register; expected from bench model
    wr(3'd1, 16'h0000);
    key = 0;
    for (int s = 0; s <= NV; s++) begin
      int best; logic [11:0] bv;
      best = -1; bv = 12'hFFF;
      for (int i = 0; i < NV; i++)
        if (VEC[i][67:56] > key[11:0] && (best < 0 || VEC[i][67:56] < bv)) begin
          best = i; bv = VEC[i][67:56];
        end
      run_cmd(16'hC000, c);
      check("R2 walk busy cycles", c, ENTRIES);
      rd(3'd1, v);
      if (best < 0) check("R7 walk end", v, 16'h0FFF);
      else begin
        logic [7:0] dm;
        check("R6 walk vid", v, {4'b0001, bv});
        rd(3'd2, v); check("R4 R3 data reg 0", v, VEC[best][47:32]);
        rd(3'd3, v); check("R4 R3 data reg 1", v, VEC[best][31:16]);
        rd(3'd4, v); check("R4 R3 data reg 2", v, VEC[best][15:0]);
        dm = VEC[best][55:48] & DBMASK;
        rd(3'd0, v); check("R8 db fields", v, {4'b0100, dm[7:4], 4'b0000, dm[3:0]});
      end
      key = {4'b0000, bv};
    end

    // R4 overwrite existing VID
    load(12'h005, 1'b1, 8'h11, 16'hBEEF, 16'h0102, 16'h0304);
    next_from(12'h004, v); check("R4 overwrite vid", v, 16'h1005);
    rd(3'd2, v); check("R4 overwrite data", v, 16'hBEEF);
    rd(3'd0, v); check("R8 overwrite db", v, 16'h4101);
    next_from(12'h005, v); check("R4 no duplicate", v, 16'h1064);

    // R5 purge existing and missing VID
    load(12'h064, 1'b0, 8'h00, 16'h0, 16'h0, 16'h0);
    next_from(12'h063, v); check("R5 purged entry skipped", v, 16'h13E8);
    load(12'h0C8, 1'b0, 8'h00, 16'h0, 16'h0, 16'h0);
    next_from(12'h0C7, v); check("R5 purge miss no effect", v, 16'h13E8);
    next_from(12'h000, v); check("R5 other entries kept", v, 16'h1001);

    // R7 boundaries
    next_from(12'hFFE, v); check("R7 above top entry", v, 16'h0FFF);
    next_from(12'hFFF, v); check("R7 key all ones", v, 16'h0FFF);

    // R10 writes while busy ignored
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'hC000);
    wr(3'd1, 16'h1777);
    wr(3'd0, 16'h9000);
    rd(3'd0, v);
    c = 0;
    while (v[15] && c < 100) begin c++; @(negedge clk); rd(3'd0, v); end
    rd(3'd1, v); check("R10 vid write during busy ignored", v, 16'h1001);
    rd(3'd0, v); check("R10 op write during busy ignored", v[14:12], 3'b100);
    run_cmd(16'hC000, c); rd(3'd1, v); check("R6 R10 walk continues unflushed", v, 16'h1005);

    // R3 VID register layout
    wr(3'd1, 16'hF123); rd(3'd1, v); check("R3 vid reg layout", v, 16'h1123);

    // R9 flush
    run_cmd(16'h9000, c); check("R2 flush busy cycles", c, 1);
    next_from(12'h000, v); check("R9 flush empties table", v, 16'h0FFF);

    // R11 full table
    for (int k = 0; k < ENTRIES; k++)
      load(12'(10 + k), 1'b1, 8'h00, 16'(k), 16'h0, 16'h0);
    load(12'(10 + ENTRIES), 1'b1, 8'h00, 16'hDEAD, 16'h0, 16'h0);
    next_from(12'(9 + ENTRIES), v); check("R11 extra load dropped", v, 16'h0FFF);
    next_from(12'h009, v); check("R11 first entry kept", v, 16'h100A);
    rd(3'd2, v); check("R11 first entry data", v, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule